// File: doc/BRIEF.md
# Dual-Bank General Register File

This block holds sixteen general registers as a processor core sees them. The low eight logical registers (R0 to R7) exist twice, once in each of two banks. The high eight (R8 to R15) exist once and are shared. A bank-select input decides which copy of R0 to R7 the normal ports reach. The normal ports are two combinational reads and one clocked write. A trap-entry input forces the second bank into view for the cycle in which it is high, so that exception and interrupt handlers always run on bank 1.

A separate alternate port uses a 3-bit index to reach the bank that is not in view. That port is privileged. When the privilege input is low, its writes are dropped and its read data is zero. All ports are plain control and data pins with no handshake: every read completes in the same cycle and every write completes at the next rising clock edge, so the block never applies back-pressure. Storage is 2×NB + NS physical words. Physical words 0 to NB−1 are bank 0, NB to 2×NB−1 are bank 1, and the rest are the shared registers.

Top module: `banked_regfile`

## Requirements
- R1: While `rst_n` is low and after it is released, every physical register holds 0. All normal reads and privileged alternate reads return 0 until something is written.
- R2: With the effective select at 0, logical indices 0 to 7 on the normal ports address bank 0. With the effective select at 1, they address bank 1. The effective select is `bank_sel` OR `trap`.
- R3: Logical indices 8 to 15 address the shared registers and give the same result for either select value.
- R4: With `priv` high, the alternate port's 3-bit index addresses the bank that is not effectively selected. `alt_rd_data` shows that register combinationally, and `alt_we` writes `alt_wr_data` into it at the next rising edge.
- R5: With `priv` low, `alt_rd_data` is 0 and an alternate write changes no register.
- R6: While `trap` is high, the block acts as if `bank_sel` were 1 for all ports: normal ports see bank 1 and the alternate port sees bank 0.
- R7: Both read ports are combinational and independent. A read of the register being written in the same cycle returns the old value, and the new value appears after the edge.
- R8: A normal write goes to the bank given by the effective select in the cycle of the write. The data stays in that bank when the select changes later.
- R9: With `wr_en` low, the normal write port changes no register, whatever `wr_idx` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 1 | Bank shown at R0 to R7 |
| trap | input | 1 | Trap entry; forces the effective select to 1 |
| priv | input | 1 | Privilege; enables the alternate port |
| rd_a_idx | input | 4 | Read port A logical index |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 4 | Read port B logical index |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Normal write logical index |
| wr_data | input | DW | Normal write data |
| alt_idx | input | 3 | Alternate port index into the hidden bank |
| alt_rd_data | output | DW | Alternate port read data |
| alt_we | input | 1 | Alternate port write enable |
| alt_wr_data | input | DW | Alternate port write data |

## Verification
The assertions check on every cycle that an enabled write is visible at its physical location after the edge. They also check that the storage holds still when neither write path is active, and that two read ports given the same index agree. The bench's scenarios are needed to show the bank mapping under both select values and the trap override. The same holds for rejected unprivileged alternate accesses, the old-value read in a write cycle, and data staying in its bank after the select changes. Each of these is compared against a behavioural model of separate bank and shared arrays.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  typedef enum logic {
    BANK_LOW  = 1'b0,
    BANK_HIGH = 1'b1
  } bank_e;

  function automatic bank_e hidden_bank(input bank_e shown);
    return (shown == BANK_HIGH) ? BANK_LOW : BANK_HIGH;
  endfunction
endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map #(
  parameter int unsigned NB = 8,
  parameter int unsigned NS = 8,
  localparam int unsigned LW = $clog2(NB + NS),
  localparam int unsigned NPHYS = 2 * NB + NS,
  localparam int unsigned PW = $clog2(NPHYS)
) (
  input  banked_rf_pkg::bank_e sel,
  input  logic [LW-1:0]        idx,
  output logic [PW-1:0]        phys
);
  localparam logic [LW-1:0] NB_L = LW'(NB);
  localparam logic [PW-1:0] NB_P = PW'(NB);
  localparam logic [PW-1:0] SH_BASE = PW'(2 * NB);

  always_comb begin
    if (idx < NB_L) begin
      phys = ((sel == banked_rf_pkg::BANK_HIGH) ? NB_P : '0) + PW'(idx);
    end else begin
      phys = SH_BASE + PW'(idx - NB_L);
    end
  end
endmodule

// File: rtl/rf_alt_guard.sv
module rf_alt_guard #(
  parameter int unsigned NB = 8,
  parameter int unsigned DW = 32,
  localparam int unsigned AW = $clog2(NB),
  localparam int unsigned PW = $clog2(3 * NB)
) (
  input  logic                 priv,
  input  banked_rf_pkg::bank_e shown,
  input  logic [AW-1:0]        idx,
  input  logic                 we_in,
  input  logic [DW-1:0]        raw_rd,
  output logic [PW-1:0]        phys,
  output logic                 we_out,
  output logic [DW-1:0]        rd_out
);
  import banked_rf_pkg::*;
  localparam logic [PW-1:0] NB_P = PW'(NB);

  bank_e tgt;
  assign tgt    = hidden_bank(shown);
  assign phys   = ((tgt == BANK_HIGH) ? NB_P : '0) + PW'(idx);
  assign we_out = we_in & priv;
  assign rd_out = priv ? raw_rd : '0;
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned DW = 32,
  parameter int unsigned NPHYS = 24,
  localparam int unsigned PW = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic [PW-1:0] pa,
  input  logic [DW-1:0] da,
  input  logic          we_b,
  input  logic [PW-1:0] pb,
  input  logic [DW-1:0] db,
  input  logic [PW-1:0] r0,
  input  logic [PW-1:0] r1,
  input  logic [PW-1:0] r2,
  output logic [DW-1:0] q0,
  output logic [DW-1:0] q1,
  output logic [DW-1:0] q2
);
  logic [DW-1:0]       regs [NPHYS];
  logic [NPHYS*DW-1:0] flat;

  for (genvar g = 0; g < NPHYS; g++) begin : g_word
    logic [DW-1:0] word;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word <= '0;
      end else if (we_a && pa == PW'(g)) begin
        word <= da;   // normal port has priority
      end else if (we_b && pb == PW'(g)) begin
        word <= db;
      end
    end
    assign regs[g] = word;
    assign flat[g*DW +: DW] = word;
  end

  assign q0 = regs[r0];
  assign q1 = regs[r1];
  assign q2 = regs[r2];

  // R8: a normal write is visible at its physical word after the edge
  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && rst_n) |=> regs[$past(pa)] == $past(da));

  // R9: no enabled write path means no register changes
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_a && !we_b && rst_n) |=> $stable(flat));

  // R4: a gated alternate write lands when the normal port does not collide
  p_alt_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_b && rst_n && !(we_a && pa == pb)) |=> regs[$past(pb)] == $past(db));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int unsigned DW = 32,
  parameter int unsigned NB = 8,
  parameter int unsigned NS = 8,
  localparam int unsigned LW = $clog2(NB + NS),
  localparam int unsigned AW = $clog2(NB),
  localparam int unsigned NPHYS = 2 * NB + NS,
  localparam int unsigned PW = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bank_sel,
  input  logic          trap,
  input  logic          priv,
  input  logic [LW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [LW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] alt_idx,
  output logic [DW-1:0] alt_rd_data,
  input  logic          alt_we,
  input  logic [DW-1:0] alt_wr_data
);
  import banked_rf_pkg::*;

  bank_e         shown;
  logic [PW-1:0] pa_rd, pb_rd, pw, palt;
  logic          alt_we_g;
  logic [DW-1:0] alt_raw;

  assign shown = (bank_sel | trap) ? BANK_HIGH : BANK_LOW;

  logic [LW-1:0] map_idx [3];
  logic [PW-1:0] map_phys [3];
  assign map_idx[0] = rd_a_idx;
  assign map_idx[1] = rd_b_idx;
  assign map_idx[2] = wr_idx;

  for (genvar m = 0; m < 3; m++) begin : g_map
    rf_bank_map #(.NB(NB), .NS(NS)) u_map (
      .sel(shown), .idx(map_idx[m]), .phys(map_phys[m]));
  end

  assign pa_rd = map_phys[0];
  assign pb_rd = map_phys[1];
  assign pw    = map_phys[2];

  rf_alt_guard #(.NB(NB), .DW(DW)) u_guard (
    .priv(priv), .shown(shown), .idx(alt_idx), .we_in(alt_we),
    .raw_rd(alt_raw), .phys(palt), .we_out(alt_we_g), .rd_out(alt_rd_data));

  rf_storage #(.DW(DW), .NPHYS(NPHYS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we_a(wr_en), .pa(pw), .da(wr_data),
    .we_b(alt_we_g), .pb(palt), .db(alt_wr_data),
    .r0(pa_rd), .r1(pb_rd), .r2(palt),
    .q0(rd_a_data), .q1(rd_b_data), .q2(alt_raw));

  // R7: the two read ports agree when given the same index
  p_ports_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == rd_b_idx) |-> rd_a_data == rd_b_data);
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        bank_sel = 0, trap = 0, priv = 0;
  logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, alt_rd_data, alt_wr_data = 0;
  logic        wr_en = 0, alt_we = 0;
  logic [2:0]  alt_idx = 0;

  int checks = 0, fails = 0;
  logic [31:0] b0 [8], b1 [8], sh [8];

  banked_regfile uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] m_rd(input logic [3:0] i, input logic s);
    if (i < 8) return s ? b1[i[2:0]] : b0[i[2:0]];
    return sh[i[2:0]];
  endfunction

  function automatic logic [31:0] m_alt(input logic [2:0] i, input logic s, input logic p);
    if (!p) return 32'h0;
    return s ? b0[i] : b1[i];
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic s, input logic t, input logic p,
                     input logic [3:0] ra, input logic [3:0] rb,
                     input logic we, input logic [3:0] wi, input logic [31:0] wd,
                     input logic awe, input logic [2:0] ai, input logic [31:0] ad);
    logic es;
    bank_sel = s; trap = t; priv = p; rd_a_idx = ra; rd_b_idx = rb;
    wr_en = we; wr_idx = wi; wr_data = wd; alt_we = awe; alt_idx = ai; alt_wr_data = ad;
    #1;
    es = s | t;
    chk(tag, "rd_a", rd_a_data, m_rd(ra, es));
    chk(tag, "rd_b", rd_b_data, m_rd(rb, es));
    chk(tag, "alt", alt_rd_data, m_alt(ai, es, p));
    @(posedge clk);
    if (p && awe) begin
      if (es) b0[ai] = ad; else b1[ai] = ad;
    end
    if (we) begin
      if (wi < 8) begin
        if (es) b1[wi[2:0]] = wd; else b0[wi[2:0]] = wd;
      end else sh[wi[2:0]] = wd;
    end
    @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic s, input logic p, input logic [3:0] ra,
                    input logic [3:0] rb, input logic [2:0] ai);
    cyc(tag, s, 1'b0, p, ra, rb, 1'b0, 4'd0, 32'h0, 1'b0, ai, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin b0[i] = 0; b1[i] = 0; sh[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: everything zero after reset
    for (int i = 0; i < 16; i++) begin
      rd("R1", 1'b0, 1'b1, 4'(i), 4'(15 - i), 3'(i));
      rd("R1", 1'b1, 1'b1, 4'(i), 4'(15 - i), 3'(i));
    end
    // R2: fill bank 0 via select 0, bank 1 via select 1
    for (int i = 0; i < 8; i++)
      cyc("R2", 1'b0, 1'b0, 1'b0, 4'(i), 4'd0, 1'b1, 4'(i), 32'h100 + i, 1'b0, 3'd0, 32'h0);
    for (int i = 0; i < 8; i++)
      cyc("R2", 1'b1, 1'b0, 1'b0, 4'(i), 4'd0, 1'b1, 4'(i), 32'h200 + i, 1'b0, 3'd0, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd("R2", 1'b0, 1'b1, 4'(i), 4'(7 - i), 3'(i));
      rd("R2", 1'b1, 1'b1, 4'(i), 4'(7 - i), 3'(i));
    end
    // R3: shared registers written under one select, read under both
    for (int i = 8; i < 16; i++)
      cyc("R3", 1'b0, 1'b0, 1'b0, 4'(i), 4'd8, 1'b1, 4'(i), 32'h300 + i, 1'b0, 3'd0, 32'h0);
    for (int i = 8; i < 16; i++) begin
      rd("R3", 1'b1, 1'b0, 4'(i), 4'(23 - i), 3'd0);
      rd("R3", 1'b0, 1'b0, 4'(i), 4'(23 - i), 3'd0);
    end
    // R4: privileged alternate writes reach the hidden bank
    cyc("R4", 1'b0, 1'b0, 1'b1, 4'd3, 4'd3, 1'b0, 4'd0, 32'h0, 1'b1, 3'd3, 32'hA1A1_0003);
    cyc("R4", 1'b1, 1'b0, 1'b1, 4'd6, 4'd3, 1'b0, 4'd0, 32'h0, 1'b1, 3'd6, 32'hB0B0_0006);
    rd("R4", 1'b1, 1'b1, 4'd3, 4'd6, 3'd6);
    rd("R4", 1'b0, 1'b1, 4'd3, 4'd6, 3'd3);
    // R5: unprivileged alternate port is rejected
    cyc("R5", 1'b0, 1'b0, 1'b0, 4'd1, 4'd2, 1'b0, 4'd0, 32'h0, 1'b1, 3'd1, 32'hDEAD_BEEF);
    cyc("R5", 1'b1, 1'b0, 1'b0, 4'd1, 4'd2, 1'b0, 4'd0, 32'h0, 1'b1, 3'd2, 32'hDEAD_BEEF);
    rd("R5", 1'b1, 1'b1, 4'd1, 4'd2, 3'd1);
    rd("R5", 1'b0, 1'b1, 4'd1, 4'd2, 3'd2);
    // R6: trap forces bank 1 into view; alternate reaches bank 0
    cyc("R6", 1'b0, 1'b1, 1'b1, 4'd4, 4'd5, 1'b1, 4'd2, 32'hC0DE_0002, 1'b1, 3'd4, 32'hC0DE_1004);
    rd("R6", 1'b1, 1'b1, 4'd2, 4'd4, 3'd4);
    rd("R6", 1'b0, 1'b1, 4'd4, 4'd2, 3'd2);
    // R7: same-cycle read of the written register gives the old value
    cyc("R7", 1'b0, 1'b0, 1'b0, 4'd7, 4'd7, 1'b1, 4'd7, 32'h7777_0007, 1'b0, 3'd0, 32'h0);
    rd("R7", 1'b0, 1'b0, 4'd7, 4'd12, 3'd0);
    cyc("R7", 1'b1, 1'b0, 1'b0, 4'd12, 4'd12, 1'b1, 4'd12, 32'h7777_000C, 1'b0, 3'd0, 32'h0);
    rd("R7", 1'b0, 1'b0, 4'd12, 4'd7, 3'd0);
    // R8: write under select 1, then flip select; data stays in bank 1
    cyc("R8", 1'b1, 1'b0, 1'b0, 4'd0, 4'd1, 1'b1, 4'd0, 32'h8888_0000, 1'b0, 3'd0, 32'h0);
    rd("R8", 1'b0, 1'b1, 4'd0, 4'd1, 3'd0);
    rd("R8", 1'b1, 1'b1, 4'd0, 4'd1, 3'd0);
    // R9: disabled write port leaves everything intact
    for (int i = 0; i < 16; i++)
      cyc("R9", 1'(i % 2), 1'b0, 1'b0, 4'(i), 4'd0, 1'b0, 4'(i), 32'hFFFF_FFFF, 1'b0, 3'd0, 32'h0);
    for (int i = 0; i < 16; i++) begin
      rd("R9", 1'b0, 1'b1, 4'(i), 4'(15 - i), 3'(i));
      rd("R9", 1'b1, 1'b1, 4'(i), 4'(15 - i), 3'(i));
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule